// File: doc/BRIEF.md
# Dual-Order Burst Word Address Sequencer

This block produces the word address for a four-beat memory burst. When either of two active-low address strobes is low at a rising clock edge, it captures the full external address. The two lowest bits of that address are kept as the burst start offset. The upper bits are held unchanged for the rest of the burst.

On every later edge where the active-low advance input is low and no strobe is active, the burst moves to the next beat. With advance high, the burst is suspended and the address does not move. A static order-select input picks the beat order:

- Order-select high gives the interleaved order, where beat k uses offset XOR k.
- Order-select low gives the linear order, where beat k uses (offset + k) modulo 4.

A board that leaves the select unconnected should pull it high, which gives the interleaved order.

Inside the block, a four-state beat machine tracks the beat index. The states are ST_BEAT0, ST_BEAT1, ST_BEAT2 and ST_BEAT3. It has three transitions:

- LOAD: any state goes to ST_BEAT0 when a strobe is active. LOAD takes priority over STEP.
- STEP: the machine moves to the next state, and ST_BEAT3 wraps to ST_BEAT0.
- HOLD: the machine stays in its current state.

The captured offset combined with the beat index forms the low two bits of the output. Both orders share the one machine. The surrounding controller decides when to load and when to advance.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset, sampled high at a rising edge, makes `word_addr_o` all zeros from that edge on.
- R2: When `strb_host_n` is low, or `strb_ctl_n` is low, or both are low at a rising edge, `word_addr_o` equals the `addr_i` sampled at that edge, from that edge on.
- R3: With `mode_intlv` = 1, each advance step makes the low two output bits equal to S XOR k, where S is the loaded offset and k = 1, 2, 3 is the beat number. Example: S=01 gives 01, 00, 11, 10.
- R4: With `mode_intlv` = 0, each advance step makes the low two output bits equal to (S + k) mod 4. Example: S=01 gives 01, 10, 11, 00.
- R5: The fourth advance after a load returns the low two bits to S in either order.
- R6: At an edge where both strobes are high and `adv_n` is high, `word_addr_o` does not change. The burst is suspended, and the next advance resumes from the held beat.
- R7: When a strobe is low and `adv_n` is low at the same edge, the load wins. The output equals the new `addr_i`, and no step is taken.
- R8: Bits above the two lowest bits of `word_addr_o` change only at a load or a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strb_host_n | input | 1 | Address strobe from the host side, active low |
| strb_ctl_n | input | 1 | Address strobe from the controller side, active low |
| adv_n | input | 1 | Advance to the next beat, active low |
| mode_intlv | input | 1 | Beat order: 1 interleaved, 0 linear (tie high when unused) |
| addr_i | input | ADDR_W | External word address, captured on a strobe |
| word_addr_o | output | ADDR_W | Word address for the memory core |

## Verification
The hardest situation to reach is a suspended burst that resumes in the middle of its sequence. It only shows up if the beat index is held while the output stays still, and it is exposed only by the step that follows the hold. The stimulus loads an offset and advances once, then holds advance high for several edges. It then advances again and expects the third beat of the chosen order. A separate scenario drives a strobe and advance low together and then steps. This shows that the load reset the beat index rather than stepping the old burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [BEAT_W-1:0] {
        ST_BEAT0 = 2'd0,
        ST_BEAT1 = 2'd1,
        ST_BEAT2 = 2'd2,
        ST_BEAT3 = 2'd3
    } beat_state_e;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_INTLV  = 1'b1
    } beat_order_e;

endpackage

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    output logic [BEAT_W-1:0] beat_idx
);

    beat_state_e state_q;
    beat_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BEAT0;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: LOAD beats STEP, otherwise HOLD
    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = ST_BEAT0;
        end else if (step) begin
            unique case (state_q)
                ST_BEAT0: state_d = ST_BEAT1;
                ST_BEAT1: state_d = ST_BEAT2;
                ST_BEAT2: state_d = ST_BEAT3;
                ST_BEAT3: state_d = ST_BEAT0;
                default:  state_d = ST_BEAT0;
            endcase
        end
    end

    // Output decode of the beat number
    always_comb begin
        unique case (state_q)
            ST_BEAT0: beat_idx = 2'd0;
            ST_BEAT1: beat_idx = 2'd1;
            ST_BEAT2: beat_idx = 2'd2;
            ST_BEAT3: beat_idx = 2'd3;
            default:  beat_idx = 2'd0;
        endcase
    end

endmodule

// File: rtl/burst_addr_capture.sv
module burst_addr_capture #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [1:0]        offset_q,
    output logic [ADDR_W-3:0] upper_q
);

    localparam int UPPER_W = ADDR_W - 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            offset_q <= 2'b00;
            upper_q  <= '0;
        end else if (load) begin
            offset_q <= addr_i[1:0];
            upper_q  <= addr_i[ADDR_W-1 -: UPPER_W];
        end
    end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
(
    input  logic              order_sel,
    input  logic [1:0]        offset,
    input  logic [BEAT_W-1:0] beat_idx,
    output logic [1:0]        low_bits
);

    logic [1:0] intlv_bits;
    logic [1:0] lin_bits;

    assign intlv_bits = offset ^ beat_idx;
    assign lin_bits   = offset + beat_idx;

    always_comb begin
        unique case (beat_order_e'(order_sel))
            ORD_INTLV:  low_bits = intlv_bits;
            ORD_LINEAR: low_bits = lin_bits;
            default:    low_bits = intlv_bits;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strb_host_n,
    input  logic              strb_ctl_n,
    input  logic              adv_n,
    input  logic              mode_intlv,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] word_addr_o
);

    localparam int UPPER_W = ADDR_W - 2;

    logic              load;
    logic              step;
    logic [1:0]        offset_q;
    logic [UPPER_W-1:0] upper_q;
    logic [BEAT_W-1:0] beat_idx;
    logic [1:0]        low_bits;

    assign load = !strb_host_n || !strb_ctl_n;
    assign step = !adv_n && !load;

    burst_addr_capture #(.ADDR_W(ADDR_W)) cap_i (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .addr_i   (addr_i),
        .offset_q (offset_q),
        .upper_q  (upper_q)
    );

    burst_beat_fsm fsm_i (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .beat_idx (beat_idx)
    );

    burst_order_map map_i (
        .order_sel (mode_intlv),
        .offset    (offset_q),
        .beat_idx  (beat_idx),
        .low_bits  (low_bits)
    );

    assign word_addr_o = {upper_q, low_bits};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              strb_host_n,
    input logic              strb_ctl_n,
    input logic              adv_n,
    input logic              mode_intlv,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] word_addr_o
);

    logic strobe_any;
    assign strobe_any = !strb_host_n || !strb_ctl_n;

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (word_addr_o == '0));                                  // R1

    AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (rst)
        strobe_any |=> (word_addr_o == $past(addr_i)));                       // R2

    AST_INTLV_FLIPS_LSB: assert property (@(posedge clk) disable iff (rst)
        (!strobe_any && !adv_n && mode_intlv) |=>
        (!$stable(mode_intlv) || (word_addr_o[0] != $past(word_addr_o[0])))); // R3

    AST_LINEAR_INCR: assert property (@(posedge clk) disable iff (rst)
        (!strobe_any && !adv_n && !mode_intlv) |=>
        (!$stable(mode_intlv) || (word_addr_o[1:0] == 2'($past(word_addr_o[1:0]) + 2'd1)))); // R4

    AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!strobe_any && adv_n) |=>
        (!$stable(mode_intlv) || $stable(word_addr_o)));                      // R6

    AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (rst)
        !strobe_any |=> $stable(word_addr_o[ADDR_W-1:2]));                    // R8

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .strb_host_n (strb_host_n),
    .strb_ctl_n  (strb_ctl_n),
    .adv_n       (adv_n),
    .mode_intlv  (mode_intlv),
    .addr_i      (addr_i),
    .word_addr_o (word_addr_o)
);

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;

    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst;
    logic          strb_host_n;
    logic          strb_ctl_n;
    logic          adv_n;
    logic          mode_intlv;
    logic [AW-1:0] addr_i;
    logic [AW-1:0] word_addr_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .strb_host_n (strb_host_n),
        .strb_ctl_n  (strb_ctl_n),
        .adv_n       (adv_n),
        .mode_intlv  (mode_intlv),
        .addr_i      (addr_i),
        .word_addr_o (word_addr_o)
    );

    // Advance to just after the next rising edge; drive and sample there
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] beat_low(bit intlv, logic [1:0] s, int k);
        logic [1:0] kk = 2'(k);
        return intlv ? (s ^ kk) : 2'(s + kk);
    endfunction

    task automatic idle_inputs();
        strb_host_n = 1'b1;
        strb_ctl_n  = 1'b1;
        adv_n       = 1'b1;
    endtask

    task automatic do_load(logic [AW-1:0] a, bit use_host);
        strb_host_n = !use_host;
        strb_ctl_n  = use_host;
        adv_n       = 1'b1;
        addr_i      = a;
        tick();
        idle_inputs();
    endtask

    task automatic do_step();
        adv_n = 1'b0;
        tick();
        adv_n = 1'b1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle_inputs();
        mode_intlv = 1'b1;
        addr_i = '0;
        tick();
        tick();
        check("R1 reset state", word_addr_o, '0);
        rst = 1'b0;
        tick();
        check("R1 after release", word_addr_o, '0);
    endtask

    task automatic t_strobes();
        do_load(15'h1235, 1'b1);
        check("R2 host strobe load", word_addr_o, 15'h1235);
        do_load(15'h6ACE, 1'b0);
        check("R2 ctl strobe load", word_addr_o, 15'h6ACE);
        strb_host_n = 1'b0; strb_ctl_n = 1'b0; addr_i = 15'h0F0F;
        tick();
        idle_inputs();
        check("R2 both strobes load", word_addr_o, 15'h0F0F);
    endtask

    task automatic t_order(bit intlv);
        mode_intlv = intlv;
        for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] base = {13'h0A5C ^ 13'(s * 97), 2'(s)};
            do_load(base, 1'b0);
            check(intlv ? "R3 beat0" : "R4 beat0", word_addr_o, base);
            for (int k = 1; k < 4; k++) begin
                do_step();
                check(intlv ? "R3 intlv beat R8 upper" : "R4 linear beat R8 upper",
                      word_addr_o, {base[AW-1:2], beat_low(intlv, 2'(s), k)});
            end
            do_step();
            check("R5 wrap to start", word_addr_o, base);
        end
    endtask

    task automatic t_suspend();
        logic [AW-1:0] base = 15'h3332;
        mode_intlv = 1'b0;
        do_load(base, 1'b1);
        do_step();
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R6 suspended hold", word_addr_o, {base[AW-1:2], 2'b11});
        end
        do_step();
        check("R6 resume after hold", word_addr_o, {base[AW-1:2], 2'b00});
    endtask

    task automatic t_priority();
        mode_intlv = 1'b1;
        do_load(15'h0101, 1'b1);
        do_step();
        strb_ctl_n = 1'b0; adv_n = 1'b0; addr_i = 15'h7FFE;
        tick();
        idle_inputs();
        check("R7 load beats advance", word_addr_o, 15'h7FFE);
        do_step();
        check("R7 beat restarted", word_addr_o, 15'h7FFF);
        tick();
        check("R8 upper kept idle", word_addr_o, 15'h7FFF);
    endtask

    initial begin
        t_reset();
        t_strobes();
        t_order(1'b1);
        t_order(1'b0);
        t_suspend();
        t_priority();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule